// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block sits between a 16-bit CPU address bus and four byte-wide targets: a 256-byte start-up ROM, the cartridge ROM, video RAM, and a general internal memory that also holds the I/O space. For every read or write it works out which target is addressed. It then raises that target's select line and hands the target a local index or address. On reads it returns the chosen target's data to the CPU.

The low 256 bytes of the cartridge window can be covered by the start-up ROM. A byte-wide lock register at 0xFF50 controls this. While the register holds zero, the start-up ROM answers in that range. The first non-zero write removes the overlay, and nothing but reset brings it back. The CPU can also address the high page in short form: it gives an 8-bit offset, and the block forms the full address from it.

Decoding, selection and the read mux are combinational, so an access completes in the cycle it is presented. Only the lock register is clocked.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the lock register is zero and `boot_active` is 1. While the lock is zero, an access to 0x0000..0x00FF raises `sel_boot`, drives `boot_idx` = address[7:0], and a read returns `boot_rdata`.
- R2: A write with a non-zero byte to effective address 0xFF50 while the lock is zero stores that byte, starting from the next cycle. From then on, reads of 0x0000..0x00FF raise `sel_cart` and return cartridge data.
- R3: Once the lock holds a non-zero value, later writes to 0xFF50, including writes of zero, leave it unchanged until reset. A read of 0xFF50 returns the stored lock value and raises no select line.
- R4: Addresses 0x0000..0x7FFF that are not claimed by the overlay raise `sel_cart` and drive `cart_addr` = address[14:0]. A read returns `cart_rdata`.
- R5: Addresses 0x8000..0x9FFF raise `sel_vram` and drive `vram_idx` = address − 0x8000. A write pulses `vram_we`, and a read returns `vram_rdata`.
- R6: Every other address except 0xFF50 raises `sel_int` and drives `int_addr` = the full effective address. A write pulses `int_we`, and a read returns `int_rdata`.
- R7: When `cpu_hipage` is 1, the effective address is 0xFF00 OR `cpu_addr[7:0]`, and the upper input bits are ignored.
- R8: Writes to the start-up or cartridge ROM ranges assert neither `vram_we` nor `int_we`, so ROM contents cannot change.
- R9: At most one select line is high at a time. All selects are low when neither `cpu_rd` nor `cpu_wr` is high. `cpu_rdata` is 0x00 when `cpu_rd` is low.
- R10: `boot_active` is 1 exactly when the overlay is enabled, that is, when the lock register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address; only bits 7:0 are used when `cpu_hipage` is 1 |
| cpu_hipage | input | 1 | Short-form high-page access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| sel_boot | output | 1 | Start-up ROM selected |
| sel_cart | output | 1 | Cartridge ROM selected |
| sel_vram | output | 1 | Video RAM selected |
| sel_int | output | 1 | Internal memory / I/O selected |
| boot_idx | output | 8 | Start-up ROM byte index |
| cart_addr | output | 15 | Cartridge ROM address |
| vram_idx | output | 13 | Video RAM index |
| int_addr | output | 16 | Internal memory address |
| tgt_wdata | output | 8 | Write data forwarded to the targets |
| vram_we | output | 1 | Video RAM write enable |
| int_we | output | 1 | Internal memory write enable |
| boot_rdata | input | 8 | Start-up ROM read data |
| cart_rdata | input | 8 | Cartridge ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| int_rdata | input | 8 | Internal memory read data |
| boot_active | output | 1 | Overlay enabled |

## Verification
The only stored state is the lock byte. If it is wrong, the effect reaches the ports in the very next access. `boot_active` flips, and a read of 0x0000..0x00FF returns cartridge bytes instead of start-up bytes, or the reverse. A read of 0xFF50 then shows the corrupted value directly. Decode errors show up in the same cycle as a wrong select line, a wrong index, or a write enable that pulses for a ROM range. The bench therefore checks selects, write enables, read data and `boot_active` on every access. It also checks them right after each write to the lock register.

// File: rtl/bod_pkg.sv
package bod_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int BOOT_AW    = 8;
    localparam int CART_AW    = 15;
    localparam int VRAM_AW    = 13;
    localparam int HIPAGE_W   = 8;

    localparam logic [ADDR_W-1:0]   LOCK_ADDR  = 16'hFF50;
    localparam logic [ADDR_W-1:0]   VRAM_BASE  = 16'h8000;
    localparam logic [HIPAGE_W-1:0] HIPAGE_HI  = 8'hFF;

    localparam int BOOT_SIZE  = 1 << BOOT_AW;
    localparam int CART_SIZE  = 1 << CART_AW;
    localparam int VRAM_SIZE  = 1 << VRAM_AW;

    typedef enum logic [2:0] {
        RG_IDLE,
        RG_BOOT,
        RG_CART,
        RG_VRAM,
        RG_INT,
        RG_LOCK
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [ADDR_W-1:0] eff;
    } decode_t;

    function automatic logic [ADDR_W-1:0] form_eff(
        input logic [ADDR_W-1:0] addr,
        input logic              hipage
    );
        if (hipage)
            return {HIPAGE_HI, addr[HIPAGE_W-1:0]};
        return addr;
    endfunction

    function automatic region_e classify(
        input logic [ADDR_W-1:0] eff,
        input logic              overlay_on
    );
        if (eff == LOCK_ADDR)
            return RG_LOCK;
        if (overlay_on && (32'(eff) < BOOT_SIZE))
            return RG_BOOT;
        if (32'(eff) < CART_SIZE)
            return RG_CART;
        if ((eff >= VRAM_BASE) && (32'(eff) < 32'(VRAM_BASE) + VRAM_SIZE))
            return RG_VRAM;
        return RG_INT;
    endfunction

endpackage

// File: rtl/bod_region_decode.sv
module bod_region_decode
    import bod_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              hipage,
    input  logic              rd,
    input  logic              wr,
    input  logic              overlay_on,
    output decode_t           dec
);
    logic [ADDR_W-1:0] eff;

    always_comb begin
        eff        = form_eff(addr, hipage);
        dec.eff    = eff;
        dec.region = RG_IDLE;
        if (rd || wr)
            dec.region = classify(eff, overlay_on);
    end
endmodule

// File: rtl/bod_boot_lock.sv
module bod_boot_lock
    import bod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lock_q,
    output logic              overlay_on
);
    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= '0;
        else if (lock_wr && (lock_q == '0))
            lock_q <= wdata;
    end

    assign overlay_on = (lock_q == '0);
endmodule

// File: rtl/bod_read_mux.sv
module bod_read_mux
    import bod_pkg::*;
(
    input  region_e           region,
    input  logic              rd,
    input  logic [DATA_W-1:0] boot_d,
    input  logic [DATA_W-1:0] cart_d,
    input  logic [DATA_W-1:0] vram_d,
    input  logic [DATA_W-1:0] int_d,
    input  logic [DATA_W-1:0] lock_d,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (region)
                RG_BOOT: rdata = boot_d;
                RG_CART: rdata = cart_d;
                RG_VRAM: rdata = vram_d;
                RG_INT:  rdata = int_d;
                RG_LOCK: rdata = lock_d;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import bod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_hipage,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               sel_boot,
    output logic               sel_cart,
    output logic               sel_vram,
    output logic               sel_int,
    output logic [BOOT_AW-1:0] boot_idx,
    output logic [CART_AW-1:0] cart_addr,
    output logic [VRAM_AW-1:0] vram_idx,
    output logic [ADDR_W-1:0]  int_addr,
    output logic [DATA_W-1:0]  tgt_wdata,
    output logic               vram_we,
    output logic               int_we,
    input  logic [DATA_W-1:0]  boot_rdata,
    input  logic [DATA_W-1:0]  cart_rdata,
    input  logic [DATA_W-1:0]  vram_rdata,
    input  logic [DATA_W-1:0]  int_rdata,
    output logic               boot_active
);
    decode_t           dec;
    logic              overlay_on;
    logic [DATA_W-1:0] lock_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] vram_off;

    bod_region_decode u_dec (
        .addr       (cpu_addr),
        .hipage     (cpu_hipage),
        .rd         (cpu_rd),
        .wr         (cpu_wr),
        .overlay_on (overlay_on),
        .dec        (dec)
    );

    bod_boot_lock u_lock (
        .clk        (clk),
        .rst        (rst),
        .lock_wr    (cpu_wr && (dec.region == RG_LOCK)),
        .wdata      (cpu_wdata),
        .lock_q     (lock_q),
        .overlay_on (overlay_on)
    );

    bod_read_mux u_mux (
        .region (dec.region),
        .rd     (cpu_rd),
        .boot_d (boot_rdata),
        .cart_d (cart_rdata),
        .vram_d (vram_rdata),
        .int_d  (int_rdata),
        .lock_d (lock_q),
        .rdata  (cpu_rdata)
    );

    assign eff_addr    = dec.eff;
    assign vram_off    = eff_addr - VRAM_BASE;

    assign sel_boot    = (dec.region == RG_BOOT);
    assign sel_cart    = (dec.region == RG_CART);
    assign sel_vram    = (dec.region == RG_VRAM);
    assign sel_int     = (dec.region == RG_INT);

    assign boot_idx    = eff_addr[BOOT_AW-1:0];
    assign cart_addr   = eff_addr[CART_AW-1:0];
    assign vram_idx    = vram_off[VRAM_AW-1:0];
    assign int_addr    = eff_addr;
    assign tgt_wdata   = cpu_wdata;

    assign vram_we     = cpu_wr && sel_vram;
    assign int_we      = cpu_wr && sel_int;
    assign boot_active = overlay_on;
endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        cpu_hipage,
    input logic [7:0]  cpu_wdata,
    input logic [15:0] eff_addr,
    input logic        sel_boot,
    input logic        sel_cart,
    input logic        sel_vram,
    input logic        sel_int,
    input logic        vram_we,
    input logic        int_we,
    input logic        boot_active
);
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_boot, sel_cart, sel_vram, sel_int}));

    p_sel_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd || cpu_wr) |-> !(sel_boot || sel_cart || sel_vram || sel_int));

    p_rom_no_we_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_boot || sel_cart) |-> !(vram_we || int_we));

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !boot_active |=> !boot_active);

    p_reset_visible_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> boot_active);

    p_boot_range_r1: assert property (@(posedge clk) disable iff (rst)
        sel_boot |-> (boot_active && (eff_addr[15:8] == 8'h00)));

    p_lock_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && boot_active && (eff_addr == 16'hFF50) && (cpu_wdata != 8'h00))
        |=> !boot_active);

    p_vram_range_r5: assert property (@(posedge clk) disable iff (rst)
        sel_vram |-> (eff_addr[15:13] == 3'b100));

    p_hipage_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_hipage |-> (eff_addr[15:8] == 8'hFF));
endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .cpu_hipage  (cpu_hipage),
    .cpu_wdata   (cpu_wdata),
    .eff_addr    (eff_addr),
    .sel_boot    (sel_boot),
    .sel_cart    (sel_cart),
    .sel_vram    (sel_vram),
    .sel_int     (sel_int),
    .vram_we     (vram_we),
    .int_we      (int_we),
    .boot_active (boot_active)
);

// File: tb/boot_overlay_decoder_tb_top.sv
`timescale 1ns/1ps
module boot_overlay_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_hipage = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        sel_boot, sel_cart, sel_vram, sel_int;
    logic [7:0]  boot_idx;
    logic [14:0] cart_addr;
    logic [12:0] vram_idx;
    logic [15:0] int_addr;
    logic [7:0]  tgt_wdata;
    logic        vram_we, int_we;
    logic [7:0]  boot_rdata, cart_rdata, vram_rdata, int_rdata;
    logic        boot_active;

    always #2.5 clk = ~clk;

    boot_overlay_decoder dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_hipage(cpu_hipage),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .sel_boot(sel_boot), .sel_cart(sel_cart),
        .sel_vram(sel_vram), .sel_int(sel_int), .boot_idx(boot_idx),
        .cart_addr(cart_addr), .vram_idx(vram_idx), .int_addr(int_addr),
        .tgt_wdata(tgt_wdata), .vram_we(vram_we), .int_we(int_we),
        .boot_rdata(boot_rdata), .cart_rdata(cart_rdata),
        .vram_rdata(vram_rdata), .int_rdata(int_rdata),
        .boot_active(boot_active)
    );

    // Memory models (environment)
    function automatic logic [7:0] boot_pat(input logic [7:0] i);
        return ~i ^ 8'h5A;
    endfunction
    function automatic logic [7:0] cart_pat(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    logic [7:0] vram_mem [64];
    logic [7:0] int_mem  [64];
    initial begin
        for (int i = 0; i < 64; i++) begin
            vram_mem[i] = 8'hFF;
            int_mem[i]  = 8'hFF;
        end
    end
    always @(posedge clk) begin
        if (vram_we) vram_mem[vram_idx[5:0]] <= tgt_wdata;
        if (int_we)  int_mem[int_addr[5:0]]  <= tgt_wdata;
    end
    assign boot_rdata = boot_pat(boot_idx);
    assign cart_rdata = cart_pat(cart_addr);
    assign vram_rdata = vram_mem[vram_idx[5:0]];
    assign int_rdata  = int_mem[int_addr[5:0]];

    // Scoreboard
    typedef struct {
        string      tag;
        logic       is_rd;
        logic [7:0] exp_data;
        logic [3:0] exp_sel;
        logic [1:0] exp_we;
        logic       exp_active;
    } item_t;

    item_t queue_q[$];
    int    n_run  = 0;
    int    n_fail = 0;

    logic [7:0] m_lock = 8'h00;
    logic [7:0] m_vram [int];
    logic [7:0] m_int  [int];

    task automatic do_check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            do_check({it.tag, " sel"}, {28'd0, sel_boot, sel_cart, sel_vram, sel_int}, {28'd0, it.exp_sel});
            do_check({it.tag, " we"}, {30'd0, vram_we, int_we}, {30'd0, it.exp_we});
            do_check({it.tag, " boot_active"}, {31'd0, boot_active}, {31'd0, it.exp_active});
            if (it.is_rd)
                do_check({it.tag, " rdata"}, {24'd0, cpu_rdata}, {24'd0, it.exp_data});
        end
    end

    task automatic access(input string tag, input logic wr, input logic [15:0] a,
                          input logic hp, input logic [7:0] wd);
        item_t       it;
        logic [15:0] eff;
        logic        ovl;
        eff = hp ? {8'hFF, a[7:0]} : a;
        ovl = (m_lock == 8'h00);
        it.tag = tag; it.is_rd = !wr; it.exp_active = ovl;
        it.exp_we = 2'b00; it.exp_data = 8'h00;
        if (eff == 16'hFF50) begin
            it.exp_sel = 4'b0000; it.exp_data = m_lock;
        end else if (ovl && eff < 16'h0100) begin
            it.exp_sel = 4'b1000; it.exp_data = boot_pat(eff[7:0]);
        end else if (eff < 16'h8000) begin
            it.exp_sel = 4'b0100; it.exp_data = cart_pat(eff[14:0]);
        end else if (eff < 16'hA000) begin
            it.exp_sel = 4'b0010; it.exp_we = {wr, 1'b0};
            it.exp_data = m_vram.exists(int'(eff)) ? m_vram[int'(eff)] : 8'hFF;
        end else begin
            it.exp_sel = 4'b0001; it.exp_we = {1'b0, wr};
            it.exp_data = m_int.exists(int'(eff)) ? m_int[int'(eff)] : 8'hFF;
        end
        @(posedge clk); #1;
        cpu_addr = a; cpu_hipage = hp; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = wd;
        queue_q.push_back(it);
        if (wr) begin
            if (eff == 16'hFF50 && m_lock == 8'h00) m_lock = wd;
            else if (it.exp_sel == 4'b0010) m_vram[int'(eff)] = wd;
            else if (it.exp_sel == 4'b0001) m_int[int'(eff)] = wd;
        end
    endtask

    task automatic idle_check(input string tag);
        @(posedge clk); #1;
        cpu_rd = 0; cpu_wr = 0; cpu_addr = 16'h0000; cpu_hipage = 0;
        #2;
        do_check({tag, " R9 idle sel"}, {28'd0, sel_boot, sel_cart, sel_vram, sel_int}, 32'd0);
        do_check({tag, " R9 idle rdata"}, {24'd0, cpu_rdata}, 32'd0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; cpu_rd = 0; cpu_wr = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0; m_lock = 8'h00;
        #2 do_check("R1 reset boot_active", {31'd0, boot_active}, 32'd1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 / R10: overlay visible
        access("R1 boot lo",    0, 16'h0000, 0, 8'h00);
        access("R1 boot hi",    0, 16'h00FF, 0, 8'h00);
        // R4: cartridge outside overlay
        access("R4 cart 0100",  0, 16'h0100, 0, 8'h00);
        access("R4 cart 7FFF",  0, 16'h7FFF, 0, 8'h00);
        // R8: rom writes ignored
        access("R8 wr boot",    1, 16'h0050, 0, 8'h99);
        access("R8 rd boot",    0, 16'h0050, 0, 8'h00);
        access("R8 wr cart",    1, 16'h4000, 0, 8'h77);
        access("R8 rd cart",    0, 16'h4000, 0, 8'h00);
        // R5: video RAM
        access("R5 wr 8000",    1, 16'h8000, 0, 8'h11);
        access("R5 wr 9FFF",    1, 16'h9FFF, 0, 8'h22);
        access("R5 rd 8000",    0, 16'h8000, 0, 8'h00);
        access("R5 rd 9FFF",    0, 16'h9FFF, 0, 8'h00);
        // R6: internal
        access("R6 wr A000",    1, 16'hA000, 0, 8'h33);
        access("R6 wr FFFF",    1, 16'hFFFF, 0, 8'h44);
        access("R6 rd A000",    0, 16'hA000, 0, 8'h00);
        access("R6 rd FFFF",    0, 16'hFFFF, 0, 8'h00);
        // R7: short-form high page (upper input bits ignored)
        access("R7 wr hp 81",   1, 16'h1281, 1, 8'h55);
        access("R7 rd hp 81",   0, 16'h3481, 1, 8'h00);
        access("R7 rd FF81",    0, 16'hFF81, 0, 8'h00);
        idle_check("mid");
        // R3: lock zero write keeps overlay
        access("R3 wr lock 0",  1, 16'hFF50, 0, 8'h00);
        access("R3 rd lock",    0, 16'hFF50, 0, 8'h00);
        access("R1 boot still", 0, 16'h0000, 0, 8'h00);
        // R2: non-zero write via high page removes overlay
        access("R2 wr lock",    1, 16'h0050, 1, 8'h01);
        access("R2 cart 0000",  0, 16'h0000, 0, 8'h00);
        access("R2 cart 00FF",  0, 16'h00FF, 0, 8'h00);
        access("R3 rd lock 1",  0, 16'hFF50, 0, 8'h00);
        access("R3 wr lock 0b", 1, 16'hFF50, 0, 8'h00);
        access("R3 wr lock 7",  1, 16'hFF50, 0, 8'h07);
        access("R3 rd lock 2",  0, 16'hFF50, 0, 8'h00);
        access("R10 cart 0010", 0, 16'h0010, 0, 8'h00);
        idle_check("end");
        // R1: reset brings overlay back
        do_reset();
        access("R1 boot again", 0, 16'h0000, 0, 8'h00);
        access("R3 rd lock rs", 0, 16'hFF50, 0, 8'h00);
        idle_check("final");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule